// File: doc/BRIEF.md
# Page-Write EEPROM Emulation Core

This core imitates a byte-alterable parallel nonvolatile memory whose host interface is asynchronous: active-low chip enable, output enable and write enable, an address bus and an 8-bit bidirectional data bus. All pins are sampled with a fast system clock. Control, address and data inputs each pass through a two-flop pipeline, so every input reaches the logic with the same two-clock delay.

Each write goes into a page buffer of up to 64 bytes. The first byte fixes the page, which is given by the address bits above bit 5. The page stays open while each new load starts within a load window, counted in system clocks. When no accepted load starts inside that window, an internal programming phase begins. It lasts a set number of clocks and then writes every loaded byte into the array at once. While programming runs, reads return a status byte in place of array data. Bit 7 of that byte is the complement of bit 7 of the last byte written, and bit 6 changes value on each read.

Top module: `pwe_core`

## Requirements
- R1: `dq` is driven only while `ce_n` and `oe_n` are both low. In that state it carries the byte stored at `addr`. Whenever either of them is high, the block leaves `dq` to other drivers.
- R2: A write cycle needs `ce_n` low, `we_n` low and `oe_n` high. Its address is taken at the moment the later of `ce_n` and `we_n` falls.
- R3: A write cycle's data is taken at the moment the earlier of `ce_n` and `we_n` rises.
- R4: The first load of a page sets the page number, which is `addr[AW-1:6]`. `addr[5:0]` selects the byte within the page. A page holds 1 to 64 bytes, and a repeated offset keeps the last value loaded.
- R5: Programming begins once `LOAD_WIN` clocks pass with no accepted load start. The count runs from the last accepted start. If a load start and the window expiry fall in the same clock, the load is taken. Before programming begins, reads return array contents.
- R6: The page has no overall time limit as long as each accepted load starts inside the window.
- R7: Programming lasts `PROG_CYC` clocks. At its end, every loaded byte of the page is written to the array together. Offsets that were not loaded, and all other pages, keep their contents.
- R8: During programming, any read returns the complement of the last written byte's bit 7 on bit 7, and that byte's true bits 5..0 on bits 5..0.
- R9: During programming, bit 6 of successive reads alternates. After programming ends it stops alternating, and reads return array data.
- R10: A load whose page differs from the open page is dropped. Its data is not stored and the load window is not restarted.
- R11: Write cycles that start during programming are dropped.
- R12: After reset the whole array reads 0x00 and no page is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | AW | Byte address; upper bits select the page |
| dq | inout | 8 | Bidirectional data bus |

## Verification
The window timer can expire in the same clock in which the next load's start is detected. The design gives that clock to the load. The bench provokes the collision by sweeping the idle gap before a second load across the window boundary, one fresh page per gap. Gaps clearly inside the window must store the second byte, and gaps clearly outside it must drop the byte. Gaps near the edge are judged by the readback: it must be either the new byte or the untouched old value, and the first byte of the page must always survive.

// File: rtl/pwe_core.sv
module pwe_core #(
  parameter int AW       = 11,
  parameter int PB       = 6,
  parameter int LOAD_WIN = 10000,
  parameter int PROG_CYC = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  inout  wire  [7:0]    dq
);
  localparam int PSZ   = 1 << PB;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW - PB;
  localparam int WCW   = $clog2(LOAD_WIN + 1);
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam logic [WCW-1:0] WIN_MAX = WCW'(LOAD_WIN - 1);
  localparam logic [PCW-1:0] PRG_MAX = PCW'(PROG_CYC - 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_LOAD = 2'd1, S_PROG = 2'd2;

  logic [1:0]    ce_p, oe_p, we_p;
  logic [AW-1:0] a_p0, a_p1;
  logic [7:0]    d_p0, d_p1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_p <= 2'b11; oe_p <= 2'b11; we_p <= 2'b11;
      a_p0 <= '0; a_p1 <= '0; d_p0 <= '0; d_p1 <= '0;
    end else begin
      ce_p <= {ce_p[0], ce_n}; oe_p <= {oe_p[0], oe_n}; we_p <= {we_p[0], we_n};
      a_p0 <= addr; a_p1 <= a_p0; d_p0 <= dq; d_p1 <= d_p0;
    end

  wire wr_act = !ce_p[1] && !we_p[1] && oe_p[1];
  wire rd_act = !ce_p[1] && !oe_p[1];
  logic wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin wr_q <= 1'b0; rd_q <= 1'b0; end
    else begin wr_q <= wr_act; rd_q <= rd_act; end

  wire wr_start = wr_act && !wr_q;
  wire wr_end   = !wr_act && wr_q;
  wire rd_end   = !rd_act && rd_q;

  logic [1:0]     st;
  logic [PW-1:0]  page_q;
  logic [AW-1:0]  cap_a;
  logic           pend;
  logic [WCW-1:0] win_cnt;
  logic [PCW-1:0] prg_cnt;
  logic [7:0]     pbuf [PSZ];
  logic [PSZ-1:0] pval;
  logic [7:0]     last_q;
  logic           tog;
  logic [7:0]     mem [DEPTH];

  wire match   = a_p1[AW-1:PB] == page_q;
  wire accept  = wr_start && (st == S_IDLE || (st == S_LOAD && match));
  wire buf_we  = wr_end && pend;
  wire to_prog = st == S_LOAD && !accept && !wr_act && win_cnt == WIN_MAX;
  wire commit  = st == S_PROG && prg_cnt == PRG_MAX;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; page_q <= '0; win_cnt <= '0; prg_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st <= S_LOAD; page_q <= a_p1[AW-1:PB]; win_cnt <= '0;
        end
        S_LOAD: if (accept) win_cnt <= '0;
          else if (to_prog) begin st <= S_PROG; prg_cnt <= '0; end
          else if (win_cnt != WIN_MAX) win_cnt <= win_cnt + 1'b1;
        default: if (commit) st <= S_IDLE;
          else prg_cnt <= prg_cnt + 1'b1;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= 1'b0; cap_a <= '0; pval <= '0; last_q <= '0; tog <= 1'b0;
      for (int i = 0; i < PSZ; i++) pbuf[i] <= '0;
    end else begin
      if (accept) begin pend <= 1'b1; cap_a <= a_p1; end
      else if (wr_end) pend <= 1'b0;
      if (buf_we) begin
        pbuf[cap_a[PB-1:0]] <= d_p1;
        pval[cap_a[PB-1:0]] <= 1'b1;
        last_q <= d_p1;
      end
      if (commit) pval <= '0;
      if (st == S_PROG && rd_end) tog <= !tog;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PSZ; i++)
        if (pval[i]) mem[{page_q, PB'(i)}] <= pbuf[i];
    end

  wire [7:0] rdata = (st == S_PROG) ? {!last_q[7], tog, last_q[5:0]} : mem[addr];
  assign dq = (!ce_n && !oe_n) ? rdata : 8'hzz;

endmodule

// File: rtl/pwe_core_chk.sv
module pwe_core_chk #(
  parameter int AW       = 11,
  parameter int PB       = 6,
  parameter int LOAD_WIN = 10000,
  parameter int PROG_CYC = 200000
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ce_n,
  input logic                           oe_n,
  input logic [7:0]                     dq,
  input logic [1:0]                     st,
  input logic [$clog2(LOAD_WIN+1)-1:0]  win_cnt,
  input logic [$clog2(PROG_CYC+1)-1:0]  prg_cnt,
  input logic [7:0]                     last_q,
  input logic                           tog,
  input logic                           buf_we,
  input logic [AW-1:0]                  cap_a,
  input logic [AW-PB-1:0]               page_q
);
  localparam logic [1:0] S_PROG = 2'd2;
  localparam int WCW = $clog2(LOAD_WIN + 1);
  localparam int PCW = $clog2(PROG_CYC + 1);

  AST_PAGE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> cap_a[AW-1:PB] == page_q);                                 // R4
  AST_WINDOW_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_PROG) |-> $past(win_cnt) == WCW'(LOAD_WIN - 1));        // R5
  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st == S_PROG) |-> $past(prg_cnt) == PCW'(PROG_CYC - 1));        // R7
  AST_STATUS_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && !ce_n && !oe_n) |-> dq[7] != last_q[7]);            // R8
  AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_PROG) |=> $stable(tog));                                     // R9
  AST_PROG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG) |=> $stable(last_q));                                  // R11
endmodule

bind pwe_core pwe_core_chk #(.AW(AW), .PB(PB), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dq(dq), .st(st),
  .win_cnt(win_cnt), .prg_cnt(prg_cnt), .last_q(last_q), .tog(tog),
  .buf_we(buf_we), .cap_a(cap_a), .page_q(page_q)
);

// File: tb/sim_pwe_core.sv
module sim_pwe_core;
  localparam int AW = 11, PB = 6, LW = 20, PC = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ce_n, oe_n, we_n, tb_drv;
  logic [AW-1:0] addr;
  logic [7:0] tb_d;
  tri   [7:0] dq;
  assign dq = tb_drv ? tb_d : 8'hzz;

  pwe_core #(.AW(AW), .PB(PB), .LOAD_WIN(LW), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq(dq));

  int checks = 0, fails = 0;

  // {address, write data, expected readback}; page 3, offsets 0, 63 and a repeated 5
  localparam logic [26:0] VEC [6] = '{
    {11'h0C0, 8'h11, 8'h11}, {11'h0FF, 8'h9E, 8'h9E}, {11'h0C5, 8'h33, 8'h7C},
    {11'h0D0, 8'h44, 8'h44}, {11'h0C5, 8'h7C, 8'h7C}, {11'h0E1, 8'hB6, 8'hB6}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; tb_d = d; tb_drv = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    idle(4);
    we_n = 1'b1; ce_n = 1'b1;
    idle(2);
    tb_drv = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    idle(2);
    d = dq;
    ce_n = 1'b1; oe_n = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, s1, s2;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; tb_drv = 1'b0;
    tb_d = '0; addr = '0;
    idle(3); rst_n = 1'b1; idle(3);

    rd(11'h000, v); chk("R12 reset low", v, 8'h00);
    rd(11'h7FF, v); chk("R12 reset high", v, 8'h00);

    // table walk: page load, then status and readback
    foreach (VEC[i]) wr(VEC[i][26:16], VEC[i][15:8]);
    rd(11'h0C0, v); chk("R5 array before expiry", v, 8'h00);
    idle(16);
    rd(11'h0E1, s1); rd(11'h0E1, s2);
    chk("R8 status bits", {s1[7], 1'b0, s1[5:0]}, {1'b0, 1'b0, 6'h36});
    chk("R9 toggle", s2[6], {7'b0, ~s1[6]});
    idle(50);
    foreach (VEC[i]) begin
      rd(VEC[i][26:16], v); chk("R4 R7 page readback", v, VEC[i][7:0]);
    end
    rd(11'h0C1, v); chk("R7 unloaded offset", v, 8'h00);
    rd(11'h100, v); chk("R7 other page", v, 8'h00);
    rd(11'h0E1, s1); rd(11'h0E1, s2);
    chk("R9 true data after", s1, 8'hB6);
    chk("R9 no toggle after", s2, 8'hB6);

    // R1: block must not drive unless both ce_n and oe_n low
    addr = 11'h0C0; tb_d = 8'h5A; tb_drv = 1'b1; ce_n = 1'b0; oe_n = 1'b1;
    idle(3); chk("R1 oe high", dq, 8'h5A);
    ce_n = 1'b1; oe_n = 1'b0;
    idle(3); chk("R1 ce high", dq, 8'h5A);
    oe_n = 1'b1; tb_drv = 1'b0; idle(3);
    rd(11'h0C0, v); chk("R1 read drives", v, 8'h11);

    // R6: loads spaced inside the window keep the page open past it
    for (int i = 0; i < 6; i++) begin wr(11'h1C0 + 11'(i), 8'h60 + 8'(i)); idle(10); end
    idle(80);
    for (int i = 0; i < 6; i++) begin rd(11'h1C0 + 11'(i), v); chk("R6 long page", v, 8'h60 + 8'(i)); end

    // R10: foreign page dropped and does not extend the window
    wr(11'h240, 8'h21); idle(2); wr(11'h280, 8'h22); idle(10); wr(11'h242, 8'h23);
    idle(80);
    rd(11'h240, v); chk("R10 first kept", v, 8'h21);
    rd(11'h280, v); chk("R10 foreign dropped", v, 8'h00);
    rd(11'h242, v); chk("R10 window not restarted", v, 8'h00);

    // R11: write during programming dropped
    wr(11'h2C0, 8'h5A); idle(22); wr(11'h2C1, 8'hA5); idle(60);
    rd(11'h2C0, v); chk("R11 page kept", v, 8'h5A);
    rd(11'h2C1, v); chk("R11 prog write dropped", v, 8'h00);

    // R2 R3: address on later fall, data on earlier rise
    tb_drv = 1'b1; tb_d = 8'hC3; addr = 11'h341; we_n = 1'b0; idle(4);
    addr = 11'h342; ce_n = 1'b0; idle(4);
    addr = 11'h341; ce_n = 1'b1; idle(4);
    tb_d = 8'h3C; we_n = 1'b1; idle(4);
    tb_drv = 1'b0; idle(80);
    rd(11'h342, v); chk("R2 R3 captured pair", v, 8'hC3);
    rd(11'h341, v); chk("R2 early address unused", v, 8'h00);

    // R5 collision sweep: next load start around window expiry
    for (int g = 12; g <= 17; g++) begin
      logic [AW-1:0] b;
      b = 11'(16 + g - 12) << PB;
      wr(b, 8'h70); idle(g); wr(b + 11'd1, 8'h71); idle(90);
      rd(b, v); chk("R5 sweep first byte", v, 8'h70);
      rd(b + 11'd1, v);
      if (g == 12) chk("R5 inside window", v, 8'h71);
      else if (g == 17) chk("R5 past window", v, 8'h00);
      else begin
        checks++;
        if (v !== 8'h71 && v !== 8'h00) begin
          fails++;
          $display("FAIL R5 edge actual=%02h expected=71 or 00", v);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule